// File: doc/BRIEF.md
# Configurable UART Transceiver Core

A full-duplex asynchronous serial transceiver clocked by the system clock. A transmitter serialises bytes written to a one-entry transmit buffer onto `txd`. A receiver takes the `rxd` line through a selectable glitch filter, rebuilds each byte and reports it in a receive register together with error flags. Both halves use the same bit clock, parity setting and data width. Each half has its own enable. A one-cycle interrupt pulse marks the end of every transmitted frame and of every received frame.

Two write-only control registers configure the core. The first register holds the two enables, the transmit stop length, the parity enable and parity sense, and a 3-bit clock code. The clock code selects one of seven system-clock divisors or an external tick input. The selected clock runs at 16 times the bit rate. The second register holds the receive stop length and the noise-filter mode.

Both halves are state machines. Transmit states: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_PAR`, `TX_STOP1`, `TX_STOP2`.
- `TX_IDLE` moves to `TX_START` when a buffer write is pending and transmit is enabled.
- Each later state lasts 16 ticks.
- `TX_DATA` repeats for 8 bits and then goes to `TX_PAR` (parity on) or `TX_STOP1`.
- `TX_STOP1` goes to `TX_STOP2` (2 stop bits) or back to `TX_IDLE`.

Receive states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PAR`, `RX_STOP1`, `RX_STOP2`.
- `RX_IDLE` moves to `RX_START` on a falling edge while receive is enabled.
- `RX_START` checks the line after 8 ticks. A high line means a false start and a return to `RX_IDLE`. A low line moves to `RX_DATA`.
- Every later bit is sampled 16 ticks after the previous one.
- The parity and stop transitions mirror those of the transmitter. The frame completes in the middle of its last stop bit.

Top module: `uartx_core`

## Requirements
- R1: After reset `txd` is 1, all flags and interrupt pulses are 0, `rx_full` is 0, and both control registers read as all-zero settings.
- R2: Control register 1 layout:
  - bit 7: transmit enable
  - bit 6: receive enable
  - bit 5: transmit stop length (0 = 1 bit, 1 = 2 bits)
  - bit 4: parity sense
  - bit 3: parity enable
  - bits 2:0: clock code

  A frame is a low start bit, then 8 data bits LSB first, then the parity bit if enabled, then 1 or 2 high stop bits. The line idles high.
- R3: With bit 4 = 1, the parity bit makes the count of ones over data and parity even. With bit 4 = 0, it makes that count odd.
- R4: Clock codes 000 to 101 give divisors 13, 26, 52, 104, 208 and 416. Code 111 gives 96. Code 110 uses one `ext_tick` pulse per tick. One bit lasts 16 ticks.
- R5: A write to control register 1 leaves the clock code unchanged while either enable is currently set.
- R6: A transmission starts only after a buffer write made while transmit is enabled. A write made while transmit is disabled is discarded, and enabling transmit does not send old buffer contents.
- R7: Clearing an enable in the middle of a frame lets that frame finish normally. No new frame starts afterwards.
- R8: The receiver samples each bit at its centre. At the end of a frame it loads `rx_byte`, sets `rx_full` and pulses `rx_done_irq` for one cycle. `rx_rd` clears `rx_full`.
- R9: `par_err` shows whether the last received frame had a parity mismatch.
- R10: Control register 2 bit 0 selects 1 or 2 receive stop bits. `frm_err` shows whether any expected stop bit of the last frame sampled low.
- R11: `ovr_err` sets when a frame completes while `rx_full` is still set and is not being read. `rx_rd` clears it.
- R12: Control register 2 bits 2:1 select the `rxd` filter:
  - 00: no filtering
  - 01: pulses shorter than 31 clocks are rejected
  - 10: pulses shorter than 63 clocks are rejected
  - 11: pulses shorter than 127 clocks are rejected
- R13: `tx_done_irq` pulses for exactly one cycle at the end of the last stop bit. `tx_busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock fc |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl1_we | input | 1 | Write strobe for control register 1 |
| ctl2_we | input | 1 | Write strobe for control register 2 (uses `ctl_wdata[2:0]`) |
| ctl_wdata | input | 8 | Control write data |
| txbuf_we | input | 1 | Write strobe for the transmit buffer |
| txbuf_wdata | input | 8 | Transmit byte |
| ext_tick | input | 1 | External tick, used when the clock code is 110 |
| rxd | input | 1 | Serial receive line |
| rx_rd | input | 1 | Read acknowledge for the received byte |
| txd | output | 1 | Serial transmit line |
| rx_byte | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte not yet read |
| tx_busy | output | 1 | Transmitter is in a frame |
| par_err | output | 1 | Parity mismatch in the last frame |
| frm_err | output | 1 | Stop bit low in the last frame |
| ovr_err | output | 1 | Unread byte was overwritten |
| tx_done_irq | output | 1 | One-cycle pulse at the end of a transmitted frame |
| rx_done_irq | output | 1 | One-cycle pulse at the end of a received frame |

## Verification
The hardest situation to reach is a control write that lands inside a frame. Examples are an enable cleared halfway through a frame, and a clock-code change attempted while a half is enabled. The stimulus reaches these cases by issuing the control write inside the bench's own bit-timing loops, at a chosen bit index. It then checks that the rest of the frame still appears intact at the pins and that nothing follows it. The clock lock is shown by timing the low run of an all-zero frame, which reveals which divisor is really in force.

// File: rtl/uartx_pkg.sv
package uartx_pkg;
    localparam int DW   = 8;
    localparam int OSR  = 16;
    localparam int OSW  = $clog2(OSR);
    localparam int BITW = $clog2(DW);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic       txe;
        logic       rxe;
        logic       tx_stop2;
        logic       par_even;
        logic       par_en;
        logic [2:0] clk_sel;
    } ctl1_t;

    typedef struct packed {
        logic [1:0] nf_mode;
        logic       rx_stop2;
    } ctl2_t;
endpackage

// File: rtl/uartx_baud.sv
module uartx_baud #(
    parameter int BASE_DIV = 13,
    parameter int ALT_DIV  = 96,
    parameter int EXT_CODE = 6,
    localparam int CW      = $clog2(BASE_DIV * 32 + ALT_DIV)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ext_tick,
    output logic       tick
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] div_c;
    logic          ext_c;
    logic          wrap_c;

    always_comb begin
        if (sel == 3'b111) div_c = CW'(ALT_DIV);
        else               div_c = CW'(BASE_DIV) << sel;
    end

    assign ext_c  = (sel == 3'(EXT_CODE));
    assign wrap_c = (cnt_q >= div_c - CW'(1));
    assign tick   = ext_c ? ext_tick : wrap_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (ext_c || wrap_c) cnt_q <= '0;
        else                      cnt_q <= cnt_q + CW'(1);
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_c && tick) |=> (!tick || sel == 3'(EXT_CODE)));
endmodule

// File: rtl/uartx_rxfilt.sv
module uartx_rxfilt #(
    parameter int SYNC = 2,
    parameter int CW   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       din,
    output logic       dout
);
    logic [SYNC-1:0] sync_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   lim_c;
    logic            s_c;

    assign s_c = sync_q[SYNC-1];

    always_comb begin
        if (mode == 2'b00) lim_c = '0;
        else               lim_c = CW'((1 << (int'(mode) + 4)) - 2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            dout   <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], din};
            if (mode == 2'b00) begin
                dout  <= s_c;
                cnt_q <= '0;
            end else if (s_c == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == lim_c) begin
                dout  <= s_c;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R12
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && $stable(mode) && cnt_q == '0 && $past(cnt_q) == '0) |-> $stable(dout));
endmodule

// File: rtl/uartx_tx.sv
module uartx_tx
    import uartx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          txe,
    input  logic          stop2,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    tx_state_e       state, nxt;
    logic [DW-1:0]   buf_q, shift_q;
    logic [OSW-1:0]  os_q;
    logic [BITW-1:0] bitn_q;
    logic            pend_q, par_q, pen_q, st2_q;
    logic            bit_end, start_c;

    assign bit_end = tick && (os_q == OSW'(OSR - 1));
    assign start_c = (state == TX_IDLE) && (nxt == TX_START);
    assign busy    = (state != TX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (txe && pend_q) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bitn_q == BITW'(DW - 1)) nxt = pen_q ? TX_PAR : TX_STOP1;
            TX_PAR:   if (bit_end) nxt = TX_STOP1;
            TX_STOP1: if (bit_end) nxt = st2_q ? TX_STOP2 : TX_IDLE;
            TX_STOP2: if (bit_end) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            shift_q <= '0;
            os_q    <= '0;
            bitn_q  <= '0;
            pend_q  <= 1'b0;
            par_q   <= 1'b0;
            pen_q   <= 1'b0;
            st2_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            if (wr && txe)    buf_q <= wdata;
            if (!txe)         pend_q <= 1'b0;
            else if (wr)      pend_q <= 1'b1;
            else if (start_c) pend_q <= 1'b0;

            if (state == TX_IDLE) os_q <= '0;
            else if (tick)        os_q <= os_q + OSW'(1);

            if (start_c) begin
                shift_q <= buf_q;
                par_q   <= par_even ? ^buf_q : ~^buf_q;
                pen_q   <= par_en;
                st2_q   <= stop2;
                bitn_q  <= '0;
            end else if (state == TX_DATA && bit_end) begin
                shift_q <= shift_q >> 1;
                bitn_q  <= bitn_q + BITW'(1);
            end

            done <= bit_end && ((state == TX_STOP1 && !st2_q) || state == TX_STOP2);
        end
    end

    // R6
    tx_start_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pend_q && txe));
    // R13
    tx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    tx_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: rtl/uartx_rx.sv
module uartx_rx
    import uartx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxe,
    input  logic          stop2,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          rxd,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          pe,
    output logic          fe,
    output logic          ovr,
    output logic          done
);
    localparam int HALF = OSR / 2;

    rx_state_e       state, nxt;
    logic [DW-1:0]   shift_q;
    logic [OSW-1:0]  os_q;
    logic [BITW-1:0] bitn_q;
    logic            prev_q, pen_q, peven_q, st2_q, pbad_q, sbad_q;
    logic            bit_end, fall_c, fin_c, fe_c;

    assign fall_c  = prev_q && !rxd;
    assign bit_end = tick && (os_q == OSW'(OSR - 1));
    assign fin_c   = bit_end && ((state == RX_STOP1 && !st2_q) || state == RX_STOP2);
    assign fe_c    = (state == RX_STOP1) ? !rxd : (sbad_q || !rxd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (rxe && fall_c) nxt = RX_START;
            RX_START: if (tick && os_q == OSW'(HALF - 1)) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bitn_q == BITW'(DW - 1)) nxt = pen_q ? RX_PAR : RX_STOP1;
            RX_PAR:   if (bit_end) nxt = RX_STOP1;
            RX_STOP1: if (bit_end) nxt = st2_q ? RX_STOP2 : RX_IDLE;
            RX_STOP2: if (bit_end) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            shift_q <= '0;
            os_q    <= '0;
            bitn_q  <= '0;
            pen_q   <= 1'b0;
            peven_q <= 1'b0;
            st2_q   <= 1'b0;
            pbad_q  <= 1'b0;
            sbad_q  <= 1'b0;
            data    <= '0;
            full    <= 1'b0;
            pe      <= 1'b0;
            fe      <= 1'b0;
            ovr     <= 1'b0;
            done    <= 1'b0;
        end else begin
            prev_q <= rxd;

            if (state == RX_IDLE)                         os_q <= '0;
            else if (state == RX_START && nxt == RX_DATA) os_q <= '0;
            else if (tick)                                os_q <= os_q + OSW'(1);

            if (state == RX_IDLE && nxt == RX_START) begin
                pen_q   <= par_en;
                peven_q <= par_even;
                st2_q   <= stop2;
                pbad_q  <= 1'b0;
                sbad_q  <= 1'b0;
                bitn_q  <= '0;
            end
            if (state == RX_DATA && bit_end) begin
                shift_q <= {rxd, shift_q[DW-1:1]};
                bitn_q  <= bitn_q + BITW'(1);
            end
            if (state == RX_PAR && bit_end)
                pbad_q <= rxd != (peven_q ? ^shift_q : ~^shift_q);
            if (state == RX_STOP1 && bit_end)
                sbad_q <= !rxd;

            done <= fin_c;
            if (fin_c) begin
                data <= shift_q;
                full <= 1'b1;
                pe   <= pen_q && pbad_q;
                fe   <= fe_c;
                if (full && !rd) ovr <= 1'b1;
                else if (rd)     ovr <= 1'b0;
            end else if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

    // R8
    rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    rx_done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> full);
    // R11
    rx_ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full));
endmodule

// File: rtl/uartx_core.sv
module uartx_core
    import uartx_pkg::*;
#(
    parameter int BASE_DIV = 13,
    parameter int ALT_DIV  = 96
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl1_we,
    input  logic          ctl2_we,
    input  logic [7:0]    ctl_wdata,
    input  logic          txbuf_we,
    input  logic [DW-1:0] txbuf_wdata,
    input  logic          ext_tick,
    input  logic          rxd,
    input  logic          rx_rd,
    output logic          txd,
    output logic [DW-1:0] rx_byte,
    output logic          rx_full,
    output logic          tx_busy,
    output logic          par_err,
    output logic          frm_err,
    output logic          ovr_err,
    output logic          tx_done_irq,
    output logic          rx_done_irq
);
    ctl1_t c1_q;
    ctl2_t c2_q;
    logic  tick, rxd_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_q <= '0;
            c2_q <= '0;
        end else begin
            if (ctl1_we) begin
                c1_q.txe      <= ctl_wdata[7];
                c1_q.rxe      <= ctl_wdata[6];
                c1_q.tx_stop2 <= ctl_wdata[5];
                c1_q.par_even <= ctl_wdata[4];
                c1_q.par_en   <= ctl_wdata[3];
                if (!(c1_q.txe || c1_q.rxe)) c1_q.clk_sel <= ctl_wdata[2:0];
            end
            if (ctl2_we) c2_q <= ctl_wdata[2:0];
        end
    end

    uartx_baud #(.BASE_DIV(BASE_DIV), .ALT_DIV(ALT_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .sel(c1_q.clk_sel), .ext_tick(ext_tick), .tick(tick)
    );

    uartx_rxfilt u_filt (
        .clk(clk), .rst_n(rst_n), .mode(c2_q.nf_mode), .din(rxd), .dout(rxd_f)
    );

    uartx_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .txe(c1_q.txe), .stop2(c1_q.tx_stop2),
        .par_en(c1_q.par_en), .par_even(c1_q.par_even), .wr(txbuf_we), .wdata(txbuf_wdata),
        .txd(txd), .busy(tx_busy), .done(tx_done_irq)
    );

    uartx_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxe(c1_q.rxe), .stop2(c2_q.rx_stop2),
        .par_en(c1_q.par_en), .par_even(c1_q.par_even), .rxd(rxd_f), .rd(rx_rd),
        .data(rx_byte), .full(rx_full), .pe(par_err), .fe(frm_err), .ovr(ovr_err),
        .done(rx_done_irq)
    );

    // R5
    clk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl1_we && (c1_q.txe || c1_q.rxe)) |=> $stable(c1_q.clk_sel));
endmodule

// File: tb/tb_uartx_core.sv
`timescale 1ns/1ps
module tb_uartx_core;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl1_we = 1'b0, ctl2_we = 1'b0, txbuf_we = 1'b0, ext_tick = 1'b1;
    logic rxd_drv = 1'b1, rx_rd = 1'b0;
    logic [7:0] ctl_wdata = '0, txbuf_wdata = '0;
    logic txd, rx_full, tx_busy, par_err, frm_err, ovr_err, tx_done_irq, rx_done_irq;
    logic [7:0] rx_byte;
    int nchk = 0, nerr = 0, txdone_n = 0, rxdone_n = 0;

    always #4 clk = ~clk;

    uartx_core dut (
        .clk(clk), .rst_n(rst_n), .ctl1_we(ctl1_we), .ctl2_we(ctl2_we), .ctl_wdata(ctl_wdata),
        .txbuf_we(txbuf_we), .txbuf_wdata(txbuf_wdata), .ext_tick(ext_tick), .rxd(rxd_drv),
        .rx_rd(rx_rd), .txd(txd), .rx_byte(rx_byte), .rx_full(rx_full), .tx_busy(tx_busy),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
        .tx_done_irq(tx_done_irq), .rx_done_irq(rx_done_irq)
    );

    always @(posedge clk) begin
        if (rst_n && tx_done_irq) txdone_n++;
        if (rst_n && rx_done_irq) rxdone_n++;
    end

    // {ctl1, data, frame length, expected parity bit, pad}
    localparam logic [23:0] VEC [8] = '{
        24'hC655A0, 24'hC6A3A0, 24'hE60FB0, 24'hCE01B0,
        24'hDE01B8, 24'hDEFFB0, 24'hFE80C8, 24'hCE00B8
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr1(input logic [7:0] v);
        @(negedge clk); ctl1_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl1_we = 1'b0;
    endtask

    task automatic wr2(input logic [2:0] v);
        @(negedge clk); ctl2_we = 1'b1; ctl_wdata = {5'b0, v};
        @(negedge clk); ctl2_we = 1'b0;
    endtask

    task automatic setc(input logic [7:0] v);
        wr1({2'b00, v[5:0]});
        wr1(v);
    endtask

    task automatic txw(input logic [7:0] d);
        @(negedge clk); txbuf_we = 1'b1; txbuf_wdata = d;
        @(negedge clk); txbuf_we = 1'b0;
    endtask

    task automatic rdp();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    function automatic logic [11:0] mkf(input logic [7:0] d, input bit pen, input bit pbit);
        logic [11:0] f;
        f = '1; f[0] = 1'b0; f[8:1] = d;
        if (pen) f[9] = pbit;
        return f;
    endfunction

    task automatic cap(input int nb, input int kill, output logic [11:0] bits);
        bits = '1;
        while (txd) @(negedge clk);
        repeat (8) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < nb; i++) begin
            if (i == kill) begin
                ctl1_we = 1'b1; ctl_wdata = 8'h06;
                @(negedge clk); ctl1_we = 1'b0;
                repeat (15) @(negedge clk);
            end else repeat (16) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic drv(input logic [11:0] bits, input int nb, input int kill);
        for (int i = 0; i < nb; i++) begin
            rxd_drv = bits[i];
            if (i == kill) begin
                ctl1_we = 1'b1; ctl_wdata = 8'h06;
                @(negedge clk); ctl1_we = 1'b0;
                repeat (15) @(negedge clk);
            end else repeat (16) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    task automatic lowrun(output int n);
        n = 0;
        while (txd) @(negedge clk);
        while (!txd) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [11:0] got, e;
        int n, t0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk({rx_full, par_err, frm_err, ovr_err, tx_busy, tx_done_irq, rx_done_irq} == '0,
            "R1 flags", int'({rx_full, par_err, frm_err, ovr_err, tx_busy}), 0);

        // table walk: R2 R3 R8 R13
        for (int k = 0; k < 8; k++) begin
            logic [7:0] c, d;
            int nb;
            c  = VEC[k][23:16];
            d  = VEC[k][15:8];
            nb = int'(VEC[k][7:4]);
            e  = mkf(d, c[3], VEC[k][3]);
            setc(c);
            wr2({2'b00, c[5]});
            t0 = txdone_n;
            txw(d);
            cap(nb, -1, got);
            repeat (16) @(negedge clk);
            chk(got == e, "R2 R3 tx frame", int'(got), int'(e));
            chk(txdone_n == t0 + 1 && !tx_busy, "R13 tx done", txdone_n - t0, 1);
            r0 = rxdone_n;
            drv(e, nb, -1);
            chk(rx_byte == d && rx_full, "R8 rx byte", int'(rx_byte), int'(d));
            chk(!par_err && !frm_err, "R9 R10 clean frame", int'({par_err, frm_err}), 0);
            chk(rxdone_n == r0 + 1, "R8 rx done", rxdone_n - r0, 1);
            rdp();
            chk(!rx_full, "R8 read clears", int'(rx_full), 0);
        end

        // R6 stale buffer not sent
        setc(8'h06);
        wr2(3'b000);
        txw(8'h3C);
        wr1(8'h86);
        n = 0;
        repeat (200) begin @(negedge clk); if (!txd) n++; end
        chk(n == 0, "R6 stale buffer", n, 0);
        txw(8'h3C);
        cap(10, -1, got);
        repeat (16) @(negedge clk);
        chk(got == mkf(8'h3C, 0, 0), "R6 fresh write", int'(got), int'(mkf(8'h3C, 0, 0)));

        // R7 tx disable mid-frame
        txw(8'h5A);
        cap(10, 4, got);
        repeat (16) @(negedge clk);
        chk(got == mkf(8'h5A, 0, 0), "R7 tx frame completes", int'(got), int'(mkf(8'h5A, 0, 0)));
        txw(8'h11);
        n = 0;
        repeat (300) begin @(negedge clk); if (!txd) n++; end
        chk(n == 0 && !tx_busy, "R7 no tx after disable", n, 0);

        // R7 rx disable mid-frame
        setc(8'h46);
        drv(mkf(8'h6D, 0, 0), 10, 4);
        chk(rx_full && rx_byte == 8'h6D, "R7 rx frame completes", int'(rx_byte), 8'h6D);
        rdp();
        drv(mkf(8'h12, 0, 0), 10, -1);
        chk(!rx_full, "R7 rx disabled", int'(rx_full), 0);

        // R9 parity error
        setc(8'h5E);
        drv(mkf(8'h01, 1, 0), 11, -1);
        chk(par_err && rx_byte == 8'h01, "R9 parity mismatch", int'(par_err), 1);
        rdp();
        drv(mkf(8'h01, 1, 1), 11, -1);
        chk(!par_err, "R9 parity ok", int'(par_err), 0);
        rdp();

        // R10 framing error, one and two stop bits
        setc(8'h46);
        e = mkf(8'h33, 0, 0); e[9] = 1'b0;
        drv(e, 10, -1);
        chk(frm_err && rx_byte == 8'h33, "R10 stop low", int'(frm_err), 1);
        rdp();
        wr2(3'b001);
        e = mkf(8'h33, 0, 0); e[10] = 1'b0;
        drv(e, 11, -1);
        chk(frm_err, "R10 second stop low", int'(frm_err), 1);
        rdp();
        drv(mkf(8'h33, 0, 0), 11, -1);
        chk(!frm_err, "R10 two stops ok", int'(frm_err), 0);
        rdp();

        // R11 overrun
        wr2(3'b000);
        drv(mkf(8'h11, 0, 0), 10, -1);
        drv(mkf(8'h22, 0, 0), 10, -1);
        chk(ovr_err && rx_byte == 8'h22, "R11 overrun set", int'(ovr_err), 1);
        rdp();
        chk(!ovr_err && !rx_full, "R11 read clears", int'({ovr_err, rx_full}), 0);

        // R12 noise filter
        wr2(3'b010);
        rxd_drv = 1'b0; repeat (20) @(negedge clk); rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(!rx_full, "R12 mode 01 rejects glitch", int'(rx_full), 0);
        wr2(3'b110);
        rxd_drv = 1'b0; repeat (100) @(negedge clk); rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(!rx_full, "R12 mode 11 rejects glitch", int'(rx_full), 0);
        wr2(3'b000);
        rxd_drv = 1'b0; repeat (20) @(negedge clk); rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(rx_full && rx_byte == 8'hFF, "R12 mode 00 passes", int'(rx_byte), 8'hFF);
        rdp();

        // R5 clock code locked while enabled; R4 divisors
        setc(8'h86);
        wr1(8'h80);
        txw(8'h00);
        lowrun(n);
        chk(n >= 143 && n <= 145, "R5 code locked", n, 144);
        repeat (40) @(negedge clk);
        wr1(8'h00); wr1(8'h80);
        txw(8'h00);
        lowrun(n);
        chk(n >= 1859 && n <= 1873, "R4 code 000", n, 1872);
        repeat (300) @(negedge clk);
        wr1(8'h00); wr1(8'h87);
        txw(8'h00);
        lowrun(n);
        chk(n >= 13728 && n <= 13825, "R4 code 111", n, 13824);
        repeat (1700) @(negedge clk);
        wr1(8'h00); wr1(8'h83);
        txw(8'h00);
        lowrun(n);
        chk(n >= 14872 && n <= 14977, "R4 code 011", n, 14976);

        finish_run();
    end
endmodule